// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block turns one external interrupt request pin into a flagged interrupt for the CPU. The pin passes through a configurable synchronizer chain and then feeds an event detector. Depending on the configuration, the detector reacts either to edges only or to edges plus the active level, and software picks whether the active direction is high or low. A detected event sets a sticky flag. Software clears the flag by writing one to an acknowledge bit. The interrupt request output is the flag gated by an enable bit, so software can also poll the flag without taking interrupts.

Software sees the whole block as a single byte-wide register. Writes are strobed by `bus_we`, and the register contents are presented on `bus_rdata` at all times. The block also drives the control for the pad's pull device. The pull is only on while the pin function is enabled and the pull has not been turned off. Its direction follows the polarity: a pull-up for active-low, a pull-down for active-high.

There are two small state machines:

- **Detector** (`DET_OFF`, `DET_ARM`, `DET_RUN`).
  - `DET_OFF` goes to `DET_ARM` when the pin is enabled.
  - `DET_ARM` goes to `DET_RUN` after one quiet cycle.
  - `DET_ARM` stays in `DET_ARM` if the polarity changes again.
  - Both `DET_ARM` and `DET_RUN` return to `DET_OFF` when the pin is disabled.
  - `DET_RUN` goes back to `DET_ARM` on a polarity change.
  - Edges are only counted in `DET_RUN`.
- **Flag** (`FLG_IDLE`, `FLG_SET`).
  - `FLG_IDLE` goes to `FLG_SET` on an event.
  - `FLG_SET` goes to `FLG_IDLE` on an acknowledge, but only in a cycle with no event.

Top module: `extint_ctrl`

## Requirements
- R1: After reset the register reads 0x00, `irq_req` is 0 and `pull_en` and `pull_down` are 0.
- R2: Register bits are as follows. Bits 6, 5, 4, 1 and 0 read back what was written. Bit 7 always reads 0. Bit 2 always reads 0. Bit 3 reads the flag and cannot be written.
  - Bit 7: reserved.
  - Bit 6: pull off.
  - Bit 5: polarity (1 = active high).
  - Bit 4: pin enable.
  - Bit 3: flag.
  - Bit 2: acknowledge.
  - Bit 1: interrupt enable.
  - Bit 0: level mode.
- R3: With the pin enabled, a pin transition to the active level sets the flag. It is visible on `bus_rdata` by the third rising clock edge after the pin changes. A transition to the inactive level never sets it.
- R4: In edge mode (bit 0 = 0), a pin held at the active level does not set the flag again after it has been acknowledged.
- R5: In level mode (bit 0 = 1), the active level sets the flag. An acknowledge does not clear the flag while the pin stays at the active level.
- R6: A write with bit 2 = 1 clears the flag when no event occurs in the same cycle. A write with bit 2 = 0 leaves the flag unchanged.
- R7: An event detected in the same cycle as an acknowledge leaves the flag set.
- R8: With the pin enable at 0, no pin activity sets the flag.
- R9: `irq_req` equals the flag AND the interrupt enable (bit 1).
- R10: `pull_en` = pin enable AND NOT pull off. `pull_down` = `pull_en` AND polarity.
- R11: Enabling the pin, or changing the polarity while the pin is steady, sets no flag in edge mode. In level mode, only a pin already at the new active level sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data |
| pin_raw | input | 1 | Asynchronous interrupt pin |
| pull_en | output | 1 | Pad pull device enable |
| pull_down | output | 1 | Pull direction: 1 pull-down, 0 pull-up |
| irq_req | output | 1 | Interrupt request to the CPU |

## Verification
The bench sweeps all four combinations of polarity and detection mode. In each one it checks:

- that an acknowledge against a held active level clears in edge mode and is refused in level mode;
- that an inactive-going edge never sets the flag;
- that flipping polarity under a steady pin flags only in level mode.

A design that let the acknowledge win would drop the flag in level mode. It would also lose the event deliberately placed in the same cycle as an acknowledge. A design that treated any pin change as an event, or ignored the enable, would set the flag on the inactive edge or while disabled. A wrong read path would show up in the exact readback patterns of the ignored bit 7, the write-only bit 2 and the read-only bit 3.

// File: rtl/extint_pkg.sv
package extint_pkg;
    localparam int REG_W      = 8;
    localparam int B_RSVD     = 7;
    localparam int B_PULL_OFF = 6;
    localparam int B_POL      = 5;
    localparam int B_PIN_ON   = 4;
    localparam int B_FLAG     = 3;
    localparam int B_ACK      = 2;
    localparam int B_IRQ_EN   = 1;
    localparam int B_LVL      = 0;

    typedef enum logic [1:0] {
        DET_OFF = 2'd0,
        DET_ARM = 2'd1,
        DET_RUN = 2'd2
    } det_state_t;

    typedef enum logic {
        FLG_IDLE = 1'b0,
        FLG_SET  = 1'b1
    } flg_state_t;

    typedef struct packed {
        logic pull_off;
        logic pol_hi;
        logic pin_on;
        logic irq_en;
        logic lvl_mode;
    } cfg_t;
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[LAST-1:0], d};
            end
        end
    endgenerate

    assign q = chain[LAST];
endmodule

// File: rtl/extint_detect.sv
module extint_detect
    import extint_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    input  logic pin_on,
    input  logic pol_hi,
    input  logic lvl_mode,
    output logic event_hit
);
    det_state_t state_q, state_d;
    logic       prev_q;
    logic       pol_q;
    logic       pol_chg;
    logic       at_active;
    logic       edge_hit;
    logic       level_hit;

    assign pol_chg   = (pol_q != pol_hi);
    assign at_active = (pin_s == pol_hi);

    // State register, previous sample and last-seen polarity
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DET_OFF;
            prev_q  <= 1'b0;
            pol_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            prev_q  <= pin_s;
            pol_q   <= pol_hi;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DET_OFF: if (pin_on) state_d = DET_ARM;
            DET_ARM: begin
                if (!pin_on)      state_d = DET_OFF;
                else if (pol_chg) state_d = DET_ARM;
                else              state_d = DET_RUN;
            end
            DET_RUN: begin
                if (!pin_on)      state_d = DET_OFF;
                else if (pol_chg) state_d = DET_ARM;
            end
            default: state_d = DET_OFF;
        endcase
    end

    // Outputs
    always_comb begin
        edge_hit  = 1'b0;
        level_hit = 1'b0;
        unique case (state_q)
            DET_OFF: ;
            DET_ARM: level_hit = pin_on & lvl_mode & at_active;
            DET_RUN: begin
                edge_hit  = pin_on & ~pol_chg & (pin_s != prev_q) & at_active;
                level_hit = pin_on & lvl_mode & at_active;
            end
            default: ;
        endcase
    end

    assign event_hit = edge_hit | level_hit;
endmodule

// File: rtl/extint_flag.sv
module extint_flag
    import extint_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic event_hit,
    input  logic ack,
    output logic flag
);
    flg_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: if (event_hit)        state_d = FLG_SET;
            FLG_SET:  if (ack && !event_hit) state_d = FLG_IDLE;
            default:  state_d = FLG_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            FLG_IDLE: flag = 1'b0;
            FLG_SET:  flag = 1'b1;
            default:  flag = 1'b0;
        endcase
    end
endmodule

// File: rtl/extint_regs.sv
module extint_regs
    import extint_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [REG_W-1:0] bus_wdata,
    input  logic             flag,
    output cfg_t             cfg,
    output logic             ack,
    output logic [REG_W-1:0] bus_rdata
);
    logic unused_wbits;
    assign unused_wbits = ^{bus_wdata[B_RSVD], bus_wdata[B_FLAG]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (bus_we) begin
            cfg.pull_off <= bus_wdata[B_PULL_OFF];
            cfg.pol_hi   <= bus_wdata[B_POL];
            cfg.pin_on   <= bus_wdata[B_PIN_ON];
            cfg.irq_en   <= bus_wdata[B_IRQ_EN];
            cfg.lvl_mode <= bus_wdata[B_LVL];
        end
    end

    assign ack = bus_we & bus_wdata[B_ACK];

    always_comb begin
        bus_rdata             = '0;
        bus_rdata[B_PULL_OFF] = cfg.pull_off;
        bus_rdata[B_POL]      = cfg.pol_hi;
        bus_rdata[B_PIN_ON]   = cfg.pin_on;
        bus_rdata[B_FLAG]     = flag;
        bus_rdata[B_IRQ_EN]   = cfg.irq_en;
        bus_rdata[B_LVL]      = cfg.lvl_mode;
    end
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
    import extint_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             pin_raw,
    output logic             pull_en,
    output logic             pull_down,
    output logic             irq_req
);
    cfg_t cfg;
    logic ack;
    logic flag;
    logic pin_s;
    logic event_hit;

    extint_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .flag      (flag),
        .cfg       (cfg),
        .ack       (ack),
        .bus_rdata (bus_rdata)
    );

    extint_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_raw),
        .q     (pin_s)
    );

    extint_detect u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_s     (pin_s),
        .pin_on    (cfg.pin_on),
        .pol_hi    (cfg.pol_hi),
        .lvl_mode  (cfg.lvl_mode),
        .event_hit (event_hit)
    );

    extint_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .event_hit (event_hit),
        .ack       (ack),
        .flag      (flag)
    );

    assign irq_req   = flag & cfg.irq_en;
    assign pull_en   = cfg.pin_on & ~cfg.pull_off;
    assign pull_down = pull_en & cfg.pol_hi;
endmodule

// File: rtl/extint_ctrl_chk.sv
module extint_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_we,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       pull_en,
    input logic       pull_down,
    input logic       irq_req
);
    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req == (bus_rdata[3] & bus_rdata[1]));

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata[7] == 1'b0) && (bus_rdata[2] == 1'b0));

    // R10
    pull_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_en == (bus_rdata[4] & ~bus_rdata[6])) &&
        (pull_down == (pull_en & bus_rdata[5])));

    // R8
    flag_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rdata[3]) |-> $past(bus_rdata[4]));

    // R6
    no_ack_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !bus_wdata[2] && bus_rdata[3]) |=> bus_rdata[3]);
endmodule

bind extint_ctrl extint_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pull_en   (pull_en),
    .pull_down (pull_down),
    .irq_req   (irq_req)
);

// File: tb/extint_ctrl_tb_top.sv
module extint_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic       pin_raw = 1'b0;
    logic [7:0] bus_rdata;
    logic       pull_en;
    logic       pull_down;
    logic       irq_req;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    extint_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_raw   (pin_raw),
        .pull_en   (pull_en),
        .pull_down (pull_down),
        .irq_req   (irq_req)
    );

    function automatic logic [7:0] cfg(input logic po, input logic pol, input logic pe,
                                       input logic ak, input logic ie, input logic lv);
        return {1'b0, po, pol, pe, 1'b0, ak, ie, lv};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        bus_we = 1'b1;
        bus_wdata = v;
        @(negedge clk);
        bus_we = 1'b0;
        bus_wdata = 8'h00;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        bus_we = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
    endtask

    initial begin
        #(8 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();
        chk("R1 rdata", bus_rdata, 8'h00);
        chk("R1 irq", irq_req, 0);
        chk("R1 pull", {pull_en, pull_down}, 0);

        // R2 field behaviour (pol high, pin low = inactive)
        pin_raw = 1'b0;
        tick(4);
        wr(8'hFF);
        chk("R2 write ff", bus_rdata, 8'h73);
        wr(8'h00);
        chk("R2 write 00", bus_rdata, 8'h00);
        wr(8'h08);
        chk("R2 flag bit not writable", bus_rdata, 8'h00);
        wr(8'h84);
        chk("R2 ack and reserved read 0", bus_rdata, 8'h00);

        // R8 disabled pin, active-low level mode
        wr(cfg(0, 0, 0, 0, 1, 1));
        tick(4);
        pin_raw = 1'b1; tick(4);
        pin_raw = 1'b0; tick(4);
        chk("R8 no flag when disabled", bus_rdata[3], 0);
        chk("R8 no irq when disabled", irq_req, 0);
        chk("R10 pull off when disabled", {pull_en, pull_down}, 0);
        wr(cfg(1, 1, 1, 0, 0, 0));
        chk("R10 pull off bit", {pull_en, pull_down}, 0);
        wr(cfg(0, 1, 1, 0, 0, 0));
        chk("R10 pull down", {pull_en, pull_down}, 3);
        wr(cfg(0, 0, 1, 0, 0, 0));
        chk("R10 pull up", {pull_en, pull_down}, 2);

        for (int pol = 0; pol < 2; pol++) begin
            for (int lv = 0; lv < 2; lv++) begin
                logic p, l;
                p = pol[0];
                l = lv[0];
                do_reset();
                pin_raw = ~p;
                tick(4);
                wr(cfg(0, p, 1, 0, 1, l));
                tick(4);
                chk("R11 enable no event", bus_rdata[3], 0);
                chk("R10 pull direction", {pull_en, pull_down}, {1'b1, p});

                pin_raw = p;
                tick(3);
                chk("R3 active edge sets flag", bus_rdata[3], 1);
                chk("R9 irq follows flag", irq_req, 1);

                wr(cfg(0, p, 1, 1, 1, l));
                chk("R5 R4 ack against held level", bus_rdata[3], lv);
                tick(4);
                chk("R4 held level no re-set", bus_rdata[3], lv);

                pin_raw = ~p;
                tick(4);
                chk("R3 inactive edge no change", bus_rdata[3], lv);
                wr(cfg(0, p, 1, 1, 1, l));
                chk("R6 ack clears", bus_rdata[3], 0);
                chk("R9 irq clears", irq_req, 0);

                pin_raw = p;
                tick(4);
                wr(cfg(0, p, 1, 0, 0, l));
                chk("R6 ack zero keeps flag", bus_rdata[3], 1);
                chk("R9 irq gated off", irq_req, 0);

                pin_raw = ~p;
                tick(4);
                if (lv == 0) begin
                    // R7: ack lands in the cycle the edge is detected
                    @(negedge clk); pin_raw = p;
                    @(negedge clk);
                    @(negedge clk);
                    bus_we = 1'b1; bus_wdata = cfg(0, p, 1, 1, 0, l);
                    @(negedge clk);
                    bus_we = 1'b0; bus_wdata = 8'h00;
                    chk("R7 event beats ack", bus_rdata[3], 1);
                    pin_raw = ~p;
                    tick(4);
                end
                wr(cfg(0, p, 1, 1, 0, l));
                chk("R6 ack clears again", bus_rdata[3], 0);

                // pin steady at ~p, which is the active level after the flip
                wr(cfg(0, ~p, 1, 0, 0, l));
                tick(4);
                chk("R11 polarity flip", bus_rdata[3], lv);
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule